// File: doc/BRIEF.md
# Integer Execute and Next-PC Unit

This block is the execute stage of a small single-cycle integer core, together with the program counter register. Each cycle, control lines already decoded from the current instruction select the two ALU operands. The first operand is register rs1 or the PC, and the second is register rs2 or the immediate. The block then conditions the second operand for the adder, runs one of eight ALU operations and raises a zero flag when the result is all zeros.

The same cycle resolves control flow. An unconditional jump sends the PC to the ALU result, with bit 0 forced low. A conditional branch tests the zero flag, optionally inverted, and takes PC plus immediate when the test holds. Otherwise the PC advances by four. The write-back value for rd is chosen among the link address (PC plus 4), the memory read data and the ALU result.

The next-PC choice is made by an enumerated selector with three named states. `NPC_JUMP` is chosen when the unconditional jump is asserted. `NPC_BRANCH` is chosen when a conditional branch is taken. `NPC_SEQ` covers everything else. The selector re-evaluates every cycle from the inputs, so any state can be followed by any other. The PC register loads the selected value on every rising edge.

Top module: `rv_exec_unit`

## Requirements
- R1: With `alu_op` = 000, `alu_result` = A + (`inv_b` ? ~B : B) + `carry_in`, modulo 2^XLEN. Subtraction is `inv_b` = `carry_in` = 1.
- R2: With `alu_op` = 001 the result is A shifted left. With 101 it is A shifted right, arithmetic when `signed_op` = 1 and logical otherwise. The shift amount is the low log2(XLEN) bits of B.
- R3: With `alu_op` = 010 the result is 1 when A < B as signed numbers, else 0. With 011 the same test is made unsigned.
- R4: `alu_op` = 100, 110 and 111 give A xor B, A or B and A and B respectively. `inv_b` and `carry_in` have no effect on these operations or on R2 and R3.
- R5: A is `pc_q` when `pc_as_a` = 1, else `rs1_val`. B is `imm_val` when `imm_as_b` = 1, else `rs2_val`.
- R6: `zero_flag` is 1 exactly when `alu_result` is all zeros.
- R7: When `jump_always` = 1, `pc_next` is `alu_result` with bit 0 cleared, whatever the branch inputs are.
- R8: Otherwise, when `jump_cond` = 1 and (`zero_flag` xor `flip_zero`) = 1, `pc_next` = `pc_q` + `imm_val`. In every other case `pc_next` = `pc_q` + 4.
- R9: `wb_data` is `pc_q` + 4 when `link_en` = 1. Otherwise it is `mem_rdata` when `mem_load` = 1, and otherwise it is `alu_result`.
- R10: `pc_q` is set to RESET_PC on a rising edge with `rst` high, and takes `pc_next` on every other rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_as_a | input | 1 | Use the PC as ALU operand A |
| imm_as_b | input | 1 | Use the immediate as ALU operand B |
| inv_b | input | 1 | Invert B on the adder path |
| carry_in | input | 1 | Adder carry-in |
| signed_op | input | 1 | Select the arithmetic right shift |
| alu_op | input | 3 | ALU operation code |
| jump_always | input | 1 | Unconditional jump to the ALU result |
| jump_cond | input | 1 | Conditional branch |
| flip_zero | input | 1 | Invert the zero flag for the branch test |
| link_en | input | 1 | Write back the link address |
| mem_load | input | 1 | Write back the memory read data |
| rs1_val | input | XLEN | Register operand 1 |
| rs2_val | input | XLEN | Register operand 2 |
| imm_val | input | XLEN | Immediate value |
| mem_rdata | input | XLEN | Memory read data |
| pc_q | output | XLEN | Current PC |
| pc_next | output | XLEN | PC to be loaded at the next edge |
| alu_result | output | XLEN | ALU result |
| zero_flag | output | 1 | ALU result is zero |
| wb_data | output | XLEN | Value for rd |

## Verification
The bench builds the unit with XLEN = 8 and RESET_PC = 8'h10. At this width a grid of operand values covers both extremes of each operand range, the sign boundary at 128 and every possible shift amount (0 to 7). That grid, crossed with all eight operation codes and every setting of the inverter, carry and signed bits, stays within a few tens of thousands of cycles. The narrow PC also lets the branch and jump sequence wrap around the address space, and it puts an odd jump target into the sequence.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SLL  = 3'b001,
        OP_SLT  = 3'b010,
        OP_SLTU = 3'b011,
        OP_XOR  = 3'b100,
        OP_SR   = 3'b101,
        OP_OR   = 3'b110,
        OP_AND  = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        NPC_SEQ,
        NPC_BRANCH,
        NPC_JUMP
    } npc_sel_e;

endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] rs2,
    input  logic [XLEN-1:0] imm,
    input  logic            pc_as_a,
    input  logic            imm_as_b,
    output logic [XLEN-1:0] op_a,
    output logic [XLEN-1:0] op_b
);
    always_comb begin
        op_a = pc_as_a  ? pc  : rs1;
        op_b = imm_as_b ? imm : rs2;
    end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            inv_b,
    input  logic            carry_in,
    input  logic            signed_op,
    output logic [XLEN-1:0] res,
    output logic            zero
);
    localparam int SHW = $clog2(XLEN);

    logic [XLEN-1:0] b_cond;
    logic [XLEN-1:0] sum;
    logic [SHW-1:0]  sh;
    logic            lt_s;
    logic            lt_u;

    always_comb begin
        b_cond = inv_b ? ~b : b;
        sum    = a + b_cond + {{(XLEN-1){1'b0}}, carry_in};
        sh     = b[SHW-1:0];
        lt_s   = $signed(a) < $signed(b);
        lt_u   = a < b;
    end

    always_comb begin
        unique case (op)
            OP_ADD:  res = sum;
            OP_SLL:  res = a << sh;
            OP_SLT:  res = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: res = {{(XLEN-1){1'b0}}, lt_u};
            OP_XOR:  res = a ^ b;
            OP_SR:   res = signed_op ? $unsigned($signed(a) >>> sh) : (a >> sh);
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            default: res = '0;
        endcase
        zero = (res == '0);
    end
endmodule

// File: rtl/exu_next_pc.sv
module exu_next_pc
    import exu_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            jump_always,
    input  logic            jump_cond,
    input  logic            flip_zero,
    input  logic            zero,
    input  logic [XLEN-1:0] alu_res,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] pc_next
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    npc_sel_e sel;

    always_comb begin
        if (jump_always)
            sel = NPC_JUMP;
        else if (jump_cond && (zero ^ flip_zero))
            sel = NPC_BRANCH;
        else
            sel = NPC_SEQ;
    end

    always_comb begin
        unique case (sel)
            NPC_JUMP:   pc_next = {alu_res[XLEN-1:1], 1'b0};
            NPC_BRANCH: pc_next = pc_q + imm;
            NPC_SEQ:    pc_next = pc_q + STEP;
            default:    pc_next = pc_q + STEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else
            pc_q <= pc_next;
    end

    assert_pc_follows_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc_q == $past(pc_next)));

    assert_jump_even_R7: assert property (@(posedge clk) disable iff (rst)
        jump_always |-> (pc_next[0] == 1'b0));
endmodule

// File: rtl/rv_exec_unit.sv
module rv_exec_unit
    import exu_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pc_as_a,
    input  logic            imm_as_b,
    input  logic            inv_b,
    input  logic            carry_in,
    input  logic            signed_op,
    input  logic [2:0]      alu_op,
    input  logic            jump_always,
    input  logic            jump_cond,
    input  logic            flip_zero,
    input  logic            link_en,
    input  logic            mem_load,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] imm_val,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] alu_result,
    output logic            zero_flag,
    output logic [XLEN-1:0] wb_data
);
    logic [XLEN-1:0] op_a;
    logic [XLEN-1:0] op_b;

    exu_operand_sel #(.XLEN(XLEN)) u_opsel (
        .pc       (pc_q),
        .rs1      (rs1_val),
        .rs2      (rs2_val),
        .imm      (imm_val),
        .pc_as_a  (pc_as_a),
        .imm_as_b (imm_as_b),
        .op_a     (op_a),
        .op_b     (op_b)
    );

    exu_alu #(.XLEN(XLEN)) u_alu (
        .op        (alu_op_e'(alu_op)),
        .a         (op_a),
        .b         (op_b),
        .inv_b     (inv_b),
        .carry_in  (carry_in),
        .signed_op (signed_op),
        .res       (alu_result),
        .zero      (zero_flag)
    );

    exu_next_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_npc (
        .clk         (clk),
        .rst         (rst),
        .jump_always (jump_always),
        .jump_cond   (jump_cond),
        .flip_zero   (flip_zero),
        .zero        (zero_flag),
        .alu_res     (alu_result),
        .imm         (imm_val),
        .pc_q        (pc_q),
        .pc_next     (pc_next)
    );

    always_comb begin
        if (link_en)
            wb_data = pc_q + XLEN'(4);
        else if (mem_load)
            wb_data = mem_rdata;
        else
            wb_data = alu_result;
    end

    // A subtraction of equal register operands must report zero.
    assert_sub_equal_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 3'b000 && inv_b && carry_in && !pc_as_a && !imm_as_b &&
         rs1_val == rs2_val) |-> zero_flag);

    assert_link_wb_R9: assert property (@(posedge clk) disable iff (rst)
        link_en |-> (wb_data == pc_q + XLEN'(4)));

    assert_mem_wb_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_load && !link_en) |-> (wb_data == mem_rdata));
endmodule

// File: tb/tb_rv_exec_unit.sv
module tb_rv_exec_unit;
    localparam int        CLK_PERIOD = 10;
    localparam int        W  = 8;
    localparam logic [7:0] RST_PC = 8'h10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pc_as_a = 0, imm_as_b = 0, inv_b = 0, carry_in = 0, signed_op = 0;
    logic [2:0] alu_op = 3'b000;
    logic       jump_always = 0, jump_cond = 0, flip_zero = 0, link_en = 0, mem_load = 0;
    logic [7:0] rs1_val = 0, rs2_val = 0, imm_val = 0, mem_rdata = 0;
    logic [7:0] pc_q, pc_next, alu_result, wb_data;
    logic       zero_flag;

    int  nvec = 0;
    int  nbad = 0;
    bit  done = 0;
    logic [7:0] exp_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    rv_exec_unit #(.XLEN(W), .RESET_PC(RST_PC)) dut (
        .clk(clk), .rst(rst), .pc_as_a(pc_as_a), .imm_as_b(imm_as_b),
        .inv_b(inv_b), .carry_in(carry_in), .signed_op(signed_op), .alu_op(alu_op),
        .jump_always(jump_always), .jump_cond(jump_cond), .flip_zero(flip_zero),
        .link_en(link_en), .mem_load(mem_load), .rs1_val(rs1_val), .rs2_val(rs2_val),
        .imm_val(imm_val), .mem_rdata(mem_rdata), .pc_q(pc_q), .pc_next(pc_next),
        .alu_result(alu_result), .zero_flag(zero_flag), .wb_data(wb_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] ref_alu(input int op, input logic [7:0] a, input logic [7:0] b,
                                           input bit sg, input bit inv, input bit ci);
        logic [7:0] bb;
        int sh;
        bb = inv ? ~b : b;
        sh = int'(b[2:0]);
        case (op)
            0: return 8'(int'(a) + int'(bb) + int'(ci));
            1: return 8'(int'(a) * (1 << sh));
            2: return ($signed(a) < $signed(b)) ? 8'd1 : 8'd0;
            3: return (a < b) ? 8'd1 : 8'd0;
            4: return a ^ b;
            5: return sg ? 8'((int'($signed(a))) >>> sh) : 8'(int'(a) / (1 << sh));
            6: return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic logic [7:0] grid(input int i);
        if (i == 37) return 8'hFF;
        if (i == 38) return 8'h80;
        return 8'(i * 7);
    endfunction

    task automatic clear_ctrl();
        pc_as_a = 0; imm_as_b = 0; inv_b = 0; carry_in = 0; signed_op = 0;
        alu_op = 3'b000; jump_always = 0; jump_cond = 0; flip_zero = 0;
        link_en = 0; mem_load = 0;
    endtask

    // Check pc_next, then the registered PC just after the edge.
    task automatic step_pc(input string tag, input logic [7:0] nxt);
        chk(tag, pc_next, nxt);
        @(posedge clk); #1;
        chk("R10 pc register load", pc_q, nxt);
        exp_pc = nxt;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, b, e;
        clear_ctrl();
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 reset value", pc_q, RST_PC);
        rst = 0;
        exp_pc = RST_PC;

        // Operation sweep: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < 39; i++) begin
            for (int j = 0; j < 39; j++) begin
                for (int op = 0; op < 8; op++) begin
                    for (int m = 0; m < 4; m++) begin
                        @(negedge clk);
                        a = grid(i); b = grid(j);
                        clear_ctrl();
                        alu_op = 3'(op);
                        rs1_val = a;
                        imm_as_b = ((i ^ j) & 1) == 1;
                        if (imm_as_b) begin imm_val = b; rs2_val = ~b; end
                        else begin rs2_val = b; imm_val = ~b; end
                        inv_b = m[1];
                        if (op == 0) carry_in = m[0];
                        else signed_op = m[0];
                        #2;
                        e = ref_alu(op, a, b, signed_op, inv_b, carry_in);
                        chk("R1/R2/R3/R4/R5 alu result", alu_result, e);
                        chk("R6 zero flag", zero_flag, (e == 0));
                        chk("R9 alu write-back", wb_data, e);
                    end
                end
            end
        end

        // Sequential step: R8
        @(negedge clk); clear_ctrl(); exp_pc = pc_q; #2;
        step_pc("R8 sequential", 8'(exp_pc + 4));

        // PC as operand A, write-back choices: R5 R9
        @(negedge clk); clear_ctrl();
        pc_as_a = 1; imm_as_b = 1; imm_val = 8'h03; link_en = 1; #2;
        chk("R5 pc operand", alu_result, 8'(exp_pc + 3));
        chk("R9 link value", wb_data, 8'(exp_pc + 4));
        link_en = 0; mem_load = 1; mem_rdata = 8'hA5; #1;
        chk("R9 memory value", wb_data, 8'hA5);
        link_en = 1; #1;
        chk("R9 link over memory", wb_data, 8'(exp_pc + 4));
        step_pc("R8 sequential after link", 8'(exp_pc + 4));

        // Jump with priority over a would-be branch: R7
        @(negedge clk); clear_ctrl();
        imm_as_b = 1; rs1_val = 8'h37; imm_val = 8'h04;
        jump_always = 1; jump_cond = 1; flip_zero = 1; #2;
        step_pc("R7 jump target", 8'h3A);
        @(negedge clk); rs1_val = 8'hFB; #2;
        step_pc("R7 odd target cleared", 8'hFE);

        // Branches: R8 R6
        @(negedge clk); clear_ctrl();
        jump_cond = 1; inv_b = 1; carry_in = 1; rs1_val = 8'h22; rs2_val = 8'h22; imm_val = 8'h0C; #2;
        chk("R6 zero on equal", zero_flag, 1);
        step_pc("R8 taken with wrap", 8'(exp_pc + 8'h0C));
        @(negedge clk); rs2_val = 8'h21; #2;
        step_pc("R8 not taken", 8'(exp_pc + 4));
        @(negedge clk); flip_zero = 1; #2;
        step_pc("R8 inverted taken", 8'(exp_pc + 8'h0C));
        @(negedge clk); rs2_val = 8'h22; #2;
        step_pc("R8 inverted not taken", 8'(exp_pc + 4));
        @(negedge clk); clear_ctrl();
        jump_cond = 1; alu_op = 3'b010; rs1_val = 8'hF0; rs2_val = 8'h05; imm_val = 8'h0C; #2;
        chk("R3 branch compare", alu_result, 8'h01);
        step_pc("R8 compare not taken", 8'(exp_pc + 4));

        // Reset in mid-run: R10
        @(negedge clk); clear_ctrl(); rst = 1;
        @(posedge clk); #1;
        chk("R10 reset mid-run", pc_q, RST_PC);
        @(negedge clk); rst = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule